// File: doc/BRIEF.md
# Write-Once Configurable Watchdog Timer

This block is a watchdog counter for a small controller. A one-bit option value is latched once after reset and fixes the mode for the whole run. In the fixed mode the counter always counts low-speed clock strobes and cannot be stopped. In the selectable mode software chooses the count source: the system clock strobe, the low-speed strobe, or none.

After reset the timeout is the longest one, 2^(MIN_EXP+7) count periods, and the source is the low-speed strobe. Software may write the configuration once. That write sets the interval in both modes and sets the source in the selectable mode. A lock flag then rises and every later write is ignored until the next reset.

A kick strobe restarts the count. When the counter reaches the selected interval, the block raises a reset request for one cycle. Counting pauses during power-saving and oscillator start-up, following the rules for each source.

Top module: `wdt_once`

## Requirements
- R1: After reset `wdt_rst_o` and `lock_o` are 0. The interval code is 7, which selects the longest timeout of 2^(MIN_EXP+7) periods, and the source is the low-speed strobe.
- R2: The mode is taken from `opt_stoppable_i` (1 = selectable, 0 = fixed) on the first clock edge after the internal reset releases. Later changes to that input have no effect until the next reset.
- R3: In fixed mode only `lsc_tick_i` advances the counter and `sys_tick_i` is ignored. A configuration write applies its interval code, and its source field is ignored, so the count can never be stopped.
- R4: In selectable mode `cfg_src_i` picks the source: 2'b01 is the low-speed strobe, 2'b10 is the system strobe, and 2'b00 or 2'b11 stops counting. With no enabled strobe the count holds.
- R5: Interval code k selects 2^(MIN_EXP+k) enabled count periods. On the enabled strobe that completes the interval, `wdt_rst_o` goes high for exactly one cycle, in the following clock cycle, and the count restarts from zero.
- R6: Only the first configuration write after reset takes effect. It sets `lock_o`, which stays high until reset, and later writes change nothing.
- R7: With the system strobe as source, counting is suspended while `halt_stop_i` or `osc_stab_i` is high.
- R8: With the low-speed strobe as source, counting is suspended during `halt_stop_i` only in selectable mode with `lsc_osc_off_i` high. Otherwise low-speed strobes keep counting during halt or stop.
- R9: `kick_i` clears the counter. A kick in the same cycle as the terminal strobe wins: no reset request is made, and a full interval follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_stoppable_i | input | 1 | Option bit: 1 = selectable mode, 0 = fixed mode |
| sys_tick_i | input | 1 | System clock count strobe |
| lsc_tick_i | input | 1 | Low-speed clock count strobe |
| halt_stop_i | input | 1 | CPU in halt or stop state |
| osc_stab_i | input | 1 | Oscillation stabilization time in progress |
| lsc_osc_off_i | input | 1 | Software has stopped the low-speed oscillator |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | SEL_W | Interval code |
| cfg_src_i | input | 2 | Count source code |
| kick_i | input | 1 | Restart strobe |
| wdt_rst_o | output | 1 | One-cycle reset request on timeout |
| lock_o | output | 1 | Configuration has been written |

## Verification
A kick and the terminal count strobe can fall in the same cycle. The bench provokes this by giving one strobe fewer than the interval and then a strobe together with `kick_i`. The collision is judged correct if no reset request appears in the next cycle and the following timeout needs a full interval of fresh strobes. A mid-interval kick is checked the same way, and the longest default interval is counted out strobe by strobe.

// File: rtl/wdt_once_pkg.sv
package wdt_once_pkg;
  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_LSC  = 2'b01,
    SRC_SYS  = 2'b10,
    SRC_OFF2 = 2'b11
  } wdt_src_e;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sr_q[STAGES-1];
endmodule

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
  import wdt_once_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opt_i,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       src_i,
  output logic             mode_b_o,
  output logic [SEL_W-1:0] sel_o,
  output wdt_src_e         src_o,
  output logic             lock_o
);
  logic             cap_q, cap_d;
  logic             mode_q, mode_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  wdt_src_e         src_q, src_d;
  logic             lock_q, lock_d;
  logic             mode_eff;

  assign mode_eff = cap_q ? mode_q : opt_i;

  always_comb begin
    cap_d  = cap_q;
    mode_d = mode_q;
    sel_d  = sel_q;
    src_d  = src_q;
    lock_d = lock_q;
    if (!cap_q) begin
      cap_d  = 1'b1;
      mode_d = opt_i;
    end
    if (we_i && !lock_q) begin
      sel_d  = sel_i;
      lock_d = 1'b1;
      if (mode_eff) src_d = wdt_src_e'(src_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= 1'b0;
      mode_q <= 1'b0;
      sel_q  <= '1;
      src_q  <= SRC_LSC;
      lock_q <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      mode_q <= mode_d;
      sel_q  <= sel_d;
      src_q  <= src_d;
      lock_q <= lock_d;
    end
  end

  assign mode_b_o = mode_eff;
  assign sel_o    = sel_q;
  assign src_o    = src_q;
  assign lock_o   = lock_q;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(sel_q) && $stable(src_q))); // R6
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q |=> $stable(mode_q)); // R2
  AST_FIXED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_q && !mode_q) |-> (src_q == SRC_LSC)); // R3
endmodule

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel
  import wdt_once_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mode_b_i,
  input  wdt_src_e src_i,
  input  logic     sys_tick_i,
  input  logic     lsc_tick_i,
  input  logic     halt_i,
  input  logic     stab_i,
  input  logic     lsc_off_i,
  output logic     cnt_en_o
);
  wdt_src_e src_eff;
  logic     sys_ok, lsc_ok;

  assign src_eff = mode_b_i ? src_i : SRC_LSC;
  assign sys_ok  = sys_tick_i && !halt_i && !stab_i;
  assign lsc_ok  = lsc_tick_i && !(halt_i && mode_b_i && lsc_off_i);

  always_comb begin
    case (src_eff)
      SRC_SYS: cnt_en_o = sys_ok;
      SRC_LSC: cnt_en_o = lsc_ok;
      default: cnt_en_o = 1'b0;
    endcase
  end

  AST_SYS_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b_i && src_i == SRC_SYS && (halt_i || stab_i)) |-> !cnt_en_o); // R7
  AST_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_tick_i || lsc_tick_i) |-> !cnt_en_o); // R4
  AST_FIXED_IGNORES_SYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_b_i && !lsc_tick_i) |-> !cnt_en_o); // R3
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int MIN_EXP = 11,
  parameter int SEL_W   = 3,
  parameter int CNT_W   = MIN_EXP + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en_i,
  input  logic             kick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             rst_req_o
);
  localparam int NSEL = 1 << SEL_W;

  logic [CNT_W-1:0] term_tab [NSEL];
  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic             hit;

  for (genvar g = 0; g < NSEL; g++) begin : g_term
    assign term_tab[g] = CNT_W'((64'd1 << (MIN_EXP + g)) - 64'd1);
  end

  assign term = term_tab[sel_i];
  assign hit  = cnt_en_i && (cnt_q >= term);

  always_comb begin
    cnt_d = cnt_q;
    req_d = 1'b0;
    if (kick_i) begin
      cnt_d = '0;
    end else if (hit) begin
      cnt_d = '0;
      req_d = 1'b1;
    end else if (cnt_en_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign rst_req_o = req_q;

  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q); // R5
  AST_RST_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(cnt_en_i)); // R5
  AST_KICK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (!req_q && cnt_q == '0)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en_i && !kick_i) |=> ($stable(cnt_q) && !req_q)); // R4
endmodule

// File: rtl/wdt_once.sv
module wdt_once
  import wdt_once_pkg::*;
#(
  parameter int MIN_EXP = 11,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opt_stoppable_i,
  input  logic             sys_tick_i,
  input  logic             lsc_tick_i,
  input  logic             halt_stop_i,
  input  logic             osc_stab_i,
  input  logic             lsc_osc_off_i,
  input  logic             cfg_we_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic [1:0]       cfg_src_i,
  input  logic             kick_i,
  output logic             wdt_rst_o,
  output logic             lock_o
);
  localparam int MAX_EXP = MIN_EXP + (1 << SEL_W) - 1;
  localparam int CNT_W   = MAX_EXP;

  logic             rst_n_s;
  logic             mode_b;
  logic [SEL_W-1:0] sel;
  wdt_src_e         src;
  logic             cnt_en;

  wdt_rst_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  wdt_cfg_reg #(.SEL_W(SEL_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .opt_i    (opt_stoppable_i),
    .we_i     (cfg_we_i),
    .sel_i    (cfg_sel_i),
    .src_i    (cfg_src_i),
    .mode_b_o (mode_b),
    .sel_o    (sel),
    .src_o    (src),
    .lock_o   (lock_o)
  );

  wdt_tick_sel u_tick (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .mode_b_i   (mode_b),
    .src_i      (src),
    .sys_tick_i (sys_tick_i),
    .lsc_tick_i (lsc_tick_i),
    .halt_i     (halt_stop_i),
    .stab_i     (osc_stab_i),
    .lsc_off_i  (lsc_osc_off_i),
    .cnt_en_o   (cnt_en)
  );

  wdt_counter #(.MIN_EXP(MIN_EXP), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cnt_en_i  (cnt_en),
    .kick_i    (kick_i),
    .sel_i     (sel),
    .rst_req_o (wdt_rst_o)
  );

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n_s)
    lock_o |=> lock_o); // R6
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (!wdt_rst_o && !lock_o)); // R1
endmodule

// File: tb/tb_wdt_once.sv
module tb_wdt_once;
  localparam int MIN_EXP = 2;
  localparam int SEL_W   = 3;

  logic clk = 1'b0;
  logic rst_n, opt, sys_tick, lsc_tick, halt, stab, lsc_off;
  logic cfg_we, kick;
  logic [SEL_W-1:0] cfg_sel;
  logic [1:0] cfg_src;
  logic wdt_rst, lock;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  wdt_once #(.MIN_EXP(MIN_EXP), .SEL_W(SEL_W)) dut (
    .clk (clk), .rst_n (rst_n), .opt_stoppable_i (opt),
    .sys_tick_i (sys_tick), .lsc_tick_i (lsc_tick),
    .halt_stop_i (halt), .osc_stab_i (stab), .lsc_osc_off_i (lsc_off),
    .cfg_we_i (cfg_we), .cfg_sel_i (cfg_sel), .cfg_src_i (cfg_src),
    .kick_i (kick), .wdt_rst_o (wdt_rst), .lock_o (lock)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit s, input bit l, input bit k);
    sys_tick = s; lsc_tick = l; kick = k;
    @(negedge clk);
    sys_tick = 0; lsc_tick = 0; kick = 0;
  endtask

  task automatic expect_pulse(input int n, input bit s, input bit l, input string req);
    int early = 0;
    for (int i = 1; i <= n; i++) begin
      step(s, l, 0);
      if (i < n && wdt_rst) early++;
      if (i == n) chk(wdt_rst == 1'b1, req, wdt_rst, 1);
    end
    chk(early == 0, req, early, 0);
    step(0, 0, 0);
    chk(wdt_rst == 1'b0, req, wdt_rst, 0);
  endtask

  task automatic expect_none(input int n, input bit s, input bit l, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      step(s, l, 0);
      if (wdt_rst) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic cfg_write(input logic [SEL_W-1:0] sel, input logic [1:0] src);
    cfg_sel = sel; cfg_src = src; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_reset(input bit o);
    rst_n = 0; opt = o;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  // R1: reset state and default longest interval in fixed mode
  task automatic t_reset_default;
    do_reset(0);
    chk(wdt_rst == 1'b0, "R1 rst_o", wdt_rst, 0);
    chk(lock == 1'b0, "R1 lock", lock, 0);
    expect_pulse(1 << (MIN_EXP + 7), 0, 1, "R1/R5 max interval");
  endtask

  // R3 R6: fixed mode ignores system strobes and the source field; write-once
  task automatic t_fixed_mode;
    cfg_write(3'd0, 2'b10);
    chk(lock == 1'b1, "R6 lock set", lock, 1);
    expect_none(12, 1, 0, "R3 sys ignored");
    expect_pulse(4, 0, 1, "R3 interval applied");
    cfg_write(3'd2, 2'b00);
    chk(lock == 1'b1, "R6 lock held", lock, 1);
    expect_pulse(4, 0, 1, "R6 second write ignored");
    halt = 1; lsc_off = 1;
    expect_pulse(4, 0, 1, "R8 fixed mode counts in halt");
    halt = 0; lsc_off = 0;
  endtask

  // R4 R6: selectable mode, stop source, later writes ignored
  task automatic t_stop_source;
    do_reset(1);
    cfg_write(3'd0, 2'b00);
    expect_none(40, 1, 1, "R4 stopped 00");
    cfg_write(3'd0, 2'b01);
    expect_none(20, 0, 1, "R6 write after lock ignored");
    do_reset(1);
    cfg_write(3'd0, 2'b11);
    expect_none(20, 1, 1, "R4 stopped 11");
  endtask

  // R4 R7: system source with suspension
  task automatic t_sys_source;
    do_reset(1);
    cfg_write(3'd1, 2'b10);
    expect_none(10, 0, 1, "R4 lsc ignored when sys");
    halt = 1;
    expect_none(10, 1, 0, "R7 halt suspends");
    halt = 0; stab = 1;
    expect_none(10, 1, 0, "R7 stab suspends");
    stab = 0;
    expect_pulse(8, 1, 0, "R5 interval 8 on sys");
  endtask

  // R8: low-speed source in selectable mode
  task automatic t_lsc_source;
    do_reset(1);
    cfg_write(3'd0, 2'b01);
    halt = 1; lsc_off = 1;
    expect_none(10, 0, 1, "R8 halt with osc off suspends");
    lsc_off = 0;
    expect_pulse(4, 0, 1, "R8 halt with osc on counts");
    halt = 0; lsc_off = 1;
    expect_pulse(4, 0, 1, "R8 osc off without halt counts");
    lsc_off = 0;
  endtask

  // R9: kick clears, kick beats terminal strobe
  task automatic t_kick;
    do_reset(1);
    cfg_write(3'd0, 2'b01);
    step(0, 1, 0); step(0, 1, 0);
    step(0, 0, 1);
    expect_pulse(4, 0, 1, "R9 kick mid count");
    step(0, 1, 0); step(0, 1, 0); step(0, 1, 0);
    step(0, 1, 1);
    chk(wdt_rst == 1'b0, "R9 kick same cycle as terminal", wdt_rst, 0);
    expect_pulse(4, 0, 1, "R9 full interval after collision");
  endtask

  // R2: option change after reset ignored
  task automatic t_opt_latch;
    do_reset(0);
    opt = 1;
    repeat (3) @(negedge clk);
    cfg_write(3'd0, 2'b00);
    expect_pulse(4, 0, 1, "R2 mode held fixed");
    do_reset(1);
    opt = 0;
    repeat (3) @(negedge clk);
    cfg_write(3'd0, 2'b00);
    expect_none(20, 1, 1, "R2 mode held selectable");
  endtask

  initial begin
    rst_n = 0; opt = 0; sys_tick = 0; lsc_tick = 0; halt = 0; stab = 0;
    lsc_off = 0; cfg_we = 0; kick = 0; cfg_sel = '0; cfg_src = '0;
    @(negedge clk);
    t_reset_default();
    t_fixed_mode();
    t_stop_source();
    t_sys_source();
    t_lsc_source();
    t_kick();
    t_opt_latch();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule